// File: doc/BRIEF.md
# Sector Lock Permission Guard

This block sits beside the command sequencer of a sectored flash array and rules on every request that could alter the array or its protection. It holds one lock bit per sector and a single master lock bit. A request names an operation and a sector index. A high-voltage override input, already reduced to a digital level, says whether the reset pin is held at its elevated level. One cycle after the request, the block answers with either a grant or a refusal. A refusal carries an error flag that tells protection-update failures apart from array-write failures.

Granted protection updates change the stored bits in the same cycle as the answer. The set-sector request locks one sector. The set-master request locks the master bit. The clear request unlocks every sector at once. Program and erase requests never change protection state. They are only checked against it.

Top module: `blkl_guard`

## Requirements
- R1: While reset is asserted and after it is released, every sector lock bit reads 0, the master lock reads 0 and no response is presented.
- R2: A request with `req_vld` high at a rising edge produces `rsp_vld` high in the next cycle, with exactly one of `rsp_grant` and `rsp_fail` high. In cycles without a preceding request, `rsp_vld`, `rsp_grant`, `rsp_fail`, `err_lock` and `err_prog` are all low.
- R3: Program (`req_op` = 0) and erase (`req_op` = 1) aimed at an unlocked sector are granted whatever the level of `hv_ovr`, and they leave all lock state unchanged.
- R4: Program or erase aimed at a locked sector is granted only when `hv_ovr` is high. Otherwise it is refused with `err_prog` high.
- R5: Set-sector-lock (`req_op` = 2) is granted at the normal level while the master lock is clear. While the master lock is set, it needs `hv_ovr` high. A grant sets `lock_vec[req_blk]`.
- R6: Set-master-lock (`req_op` = 3) is granted only with `hv_ovr` high, and a grant sets `mstr_lock`. Only reset clears `mstr_lock`.
- R7: Clear-all (`req_op` = 4) is granted at the normal level while the master lock is clear. While the master lock is set, it needs `hv_ovr` high. A grant clears every sector lock bit in the same operation.
- R8: A refused protection update (codes 2, 3, 4) raises `err_lock` and not `err_prog`. A refused program or erase raises `err_prog` and not `err_lock`.
- R9: A refused request leaves `lock_vec` and `mstr_lock` unchanged.
- R10: Reserved codes 5, 6 and 7 are refused with both error flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_vld | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (0 program, 1 erase, 2 set sector lock, 3 set master lock, 4 clear all, 5-7 reserved) |
| req_blk | input | IDXW | Sector index |
| hv_ovr | input | 1 | High-voltage override level |
| rsp_vld | output | 1 | Response present |
| rsp_grant | output | 1 | Request permitted |
| rsp_fail | output | 1 | Request refused |
| err_lock | output | 1 | Refusal of a protection update |
| err_prog | output | 1 | Refusal of a program or erase |
| lock_vec | output | NBLK | Current sector lock bits |
| mstr_lock | output | 1 | Current master lock bit |

## Verification
Every response, and every change to `lock_vec` or `mstr_lock` caused by a request, is due exactly one rising edge after the edge that samples the request. The bench drives each request on a falling edge and samples all outputs on the next falling edge, which falls after that one rising edge. It also samples one idle falling edge later to confirm that the response has dropped. The assertions use the same one-cycle spacing through `|=>` and `$past` of depth one.

// File: rtl/blkl_pkg.sv
package blkl_pkg;

  localparam logic [2:0] OPC_PROG     = 3'd0;
  localparam logic [2:0] OPC_ERASE    = 3'd1;
  localparam logic [2:0] OPC_SET_BLK  = 3'd2;
  localparam logic [2:0] OPC_SET_MSTR = 3'd3;
  localparam logic [2:0] OPC_CLR_ALL  = 3'd4;

  typedef struct packed {
    logic vld;
    logic grant;
    logic fail;
    logic err_lock;
    logic err_prog;
  } resp_t;

endpackage

// File: rtl/blkl_rst_sync.sv
module blkl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] shf_q;
  logic [STAGES-1:0] shf_d;

  always_comb begin
    shf_d = {shf_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shf_q <= '0;
    else        shf_q <= shf_d;
  end

  assign rst_q_n = shf_q[STAGES-1];
endmodule

// File: rtl/blkl_rules.sv
module blkl_rules
  import blkl_pkg::*;
#(
  parameter int NBLK = 64,
  parameter int IDXW = 6
) (
  input  logic            req_vld,
  input  logic [2:0]      req_op,
  input  logic [IDXW-1:0] req_blk,
  input  logic            hv_ovr,
  input  logic [NBLK-1:0] lock_q,
  input  logic            mstr_q,
  output resp_t           resp_d,
  output logic            set_blk_en,
  output logic            set_mstr_en,
  output logic            clr_all_en
);
  localparam logic [IDXW:0] NBLK_W = NBLK[IDXW:0];

  logic in_range;
  logic blk_locked;
  logic is_pe;
  logic is_lk;
  logic ok;

  always_comb begin
    in_range   = ({1'b0, req_blk} < NBLK_W);
    blk_locked = in_range && lock_q[req_blk];
    is_pe      = 1'b0;
    is_lk      = 1'b0;
    ok         = 1'b0;
    case (req_op)
      OPC_PROG, OPC_ERASE: begin
        is_pe = 1'b1;
        ok    = in_range && (!blk_locked || hv_ovr);
      end
      OPC_SET_BLK: begin
        is_lk = 1'b1;
        ok    = in_range && (!mstr_q || hv_ovr);
      end
      OPC_SET_MSTR: begin
        is_lk = 1'b1;
        ok    = hv_ovr;
      end
      OPC_CLR_ALL: begin
        is_lk = 1'b1;
        ok    = !mstr_q || hv_ovr;
      end
      default: begin
        ok = 1'b0;
      end
    endcase

    resp_d.vld      = req_vld;
    resp_d.grant    = req_vld && ok;
    resp_d.fail     = req_vld && !ok;
    resp_d.err_prog = req_vld && !ok && is_pe;
    resp_d.err_lock = req_vld && !ok && is_lk;

    set_blk_en  = req_vld && ok && (req_op == OPC_SET_BLK);
    set_mstr_en = req_vld && ok && (req_op == OPC_SET_MSTR);
    clr_all_en  = req_vld && ok && (req_op == OPC_CLR_ALL);
  end
endmodule

// File: rtl/blkl_store.sv
module blkl_store #(
  parameter int NBLK = 64,
  parameter int IDXW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_blk_en,
  input  logic [IDXW-1:0] set_idx,
  input  logic            set_mstr_en,
  input  logic            clr_all_en,
  output logic [NBLK-1:0] lock_q,
  output logic            mstr_q
);
  logic mstr_d;
  logic mstr_ce;

  for (genvar gi = 0; gi < NBLK; gi++) begin : g_blk
    logic bit_d;
    logic bit_ce;

    always_comb begin
      bit_ce = clr_all_en || (set_blk_en && (set_idx == IDXW'(gi)));
      bit_d  = !clr_all_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lock_q[gi] <= 1'b0;
      else if (bit_ce) lock_q[gi] <= bit_d;
    end
  end

  always_comb begin
    mstr_ce = set_mstr_en;
    mstr_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mstr_q <= 1'b0;
    else if (mstr_ce) mstr_q <= mstr_d;
  end
endmodule

// File: rtl/blkl_resp.sv
module blkl_resp
  import blkl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  resp_t resp_d,
  output resp_t resp_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resp_q <= '0;
    else        resp_q <= resp_d;
  end
endmodule

// File: rtl/blkl_guard.sv
module blkl_guard
  import blkl_pkg::*;
#(
  parameter int NBLK = 64,
  localparam int IDXW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_vld,
  input  logic [2:0]      req_op,
  input  logic [IDXW-1:0] req_blk,
  input  logic            hv_ovr,
  output logic            rsp_vld,
  output logic            rsp_grant,
  output logic            rsp_fail,
  output logic            err_lock,
  output logic            err_prog,
  output logic [NBLK-1:0] lock_vec,
  output logic            mstr_lock
);
  logic            rst_q_n;
  resp_t           resp_d;
  resp_t           resp_q;
  logic            set_blk_en;
  logic            set_mstr_en;
  logic            clr_all_en;
  logic [NBLK-1:0] lock_q;
  logic            mstr_q;

  blkl_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  blkl_rules #(.NBLK(NBLK), .IDXW(IDXW)) u_rules (
    .req_vld     (req_vld),
    .req_op      (req_op),
    .req_blk     (req_blk),
    .hv_ovr      (hv_ovr),
    .lock_q      (lock_q),
    .mstr_q      (mstr_q),
    .resp_d      (resp_d),
    .set_blk_en  (set_blk_en),
    .set_mstr_en (set_mstr_en),
    .clr_all_en  (clr_all_en)
  );

  blkl_store #(.NBLK(NBLK), .IDXW(IDXW)) u_store (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .set_blk_en  (set_blk_en),
    .set_idx     (req_blk),
    .set_mstr_en (set_mstr_en),
    .clr_all_en  (clr_all_en),
    .lock_q      (lock_q),
    .mstr_q      (mstr_q)
  );

  blkl_resp u_resp (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .resp_d (resp_d),
    .resp_q (resp_q)
  );

  assign rsp_vld   = resp_q.vld;
  assign rsp_grant = resp_q.grant;
  assign rsp_fail  = resp_q.fail;
  assign err_lock  = resp_q.err_lock;
  assign err_prog  = resp_q.err_prog;
  assign lock_vec  = lock_q;
  assign mstr_lock = mstr_q;
endmodule

// File: rtl/blkl_guard_chk.sv
module blkl_guard_chk #(
  parameter int NBLK = 64,
  parameter int IDXW = 6
) (
  input logic            clk,
  input logic            rst_q_n,
  input logic            req_vld,
  input logic [2:0]      req_op,
  input logic [IDXW-1:0] req_blk,
  input logic            hv_ovr,
  input logic            rsp_vld,
  input logic            rsp_grant,
  input logic            rsp_fail,
  input logic            err_lock,
  input logic            err_prog,
  input logic [NBLK-1:0] lock_vec,
  input logic            mstr_lock
);
  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    rsp_vld |-> (rsp_grant ^ rsp_fail));

  assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !rsp_vld |-> !(rsp_grant || rsp_fail || err_lock || err_prog));

  assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_vld |=> rsp_vld);

  assert_unlocked_pe_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_vld && (req_op == 3'd0 || req_op == 3'd1) && !lock_vec[req_blk]) |=> rsp_grant);

  assert_locked_pe_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_vld && (req_op == 3'd0 || req_op == 3'd1) && lock_vec[req_blk] && !hv_ovr)
      |=> (rsp_fail && err_prog && !err_lock));

  assert_mstr_needs_hv_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_vld && req_op == 3'd3 && !hv_ovr) |=> (rsp_fail && err_lock && !err_prog));

  assert_mstr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    !$fell(mstr_lock));

  assert_clear_all_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_vld && req_op == 3'd4 && (!mstr_lock || hv_ovr)) |=> (lock_vec == '0));

  assert_fail_keeps_state_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    rsp_fail |-> ($stable(lock_vec) && $stable(mstr_lock)));

  assert_reserved_no_err_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_vld && req_op > 3'd4) |=> (rsp_fail && !err_lock && !err_prog));
endmodule

bind blkl_guard blkl_guard_chk #(.NBLK(NBLK), .IDXW(IDXW)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .req_vld   (req_vld),
  .req_op    (req_op),
  .req_blk   (req_blk),
  .hv_ovr    (hv_ovr),
  .rsp_vld   (rsp_vld),
  .rsp_grant (rsp_grant),
  .rsp_fail  (rsp_fail),
  .err_lock  (err_lock),
  .err_prog  (err_prog),
  .lock_vec  (lock_vec),
  .mstr_lock (mstr_lock)
);

// File: tb/blkl_guard_tb_top.sv
`timescale 1ns/1ps
module blkl_guard_tb_top;
  localparam int NB = 64;
  localparam int IW = $clog2(NB);

  logic          clk;
  logic          rst_n;
  logic          req_vld;
  logic [2:0]    req_op;
  logic [IW-1:0] req_blk;
  logic          hv_ovr;
  logic          rsp_vld, rsp_grant, rsp_fail, err_lock, err_prog;
  logic [NB-1:0] lock_vec;
  logic          mstr_lock;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  bit [NB-1:0] m_lock;
  bit          m_mstr;

  blkl_guard #(.NBLK(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_op(req_op),
    .req_blk(req_blk), .hv_ovr(hv_ovr), .rsp_vld(rsp_vld),
    .rsp_grant(rsp_grant), .rsp_fail(rsp_fail), .err_lock(err_lock),
    .err_prog(err_prog), .lock_vec(lock_vec), .mstr_lock(mstr_lock)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_ok(input logic [2:0] op, input int blk, input logic hv);
    case (op)
      3'd0, 3'd1: return !m_lock[blk] || hv;
      3'd2:       return !m_mstr || hv;
      3'd3:       return hv;
      3'd4:       return !m_mstr || hv;
      default:    return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] op, input int blk);
    case (op)
      3'd0, 3'd1: return m_lock[blk] ? "R4" : "R3";
      3'd2:       return "R5";
      3'd3:       return "R6";
      3'd4:       return "R7";
      default:    return "R10";
    endcase
  endfunction

  // Called at a falling edge; returns at the falling edge after the response.
  task automatic issue(input logic [2:0] op, input int blk, input logic hv);
    bit    ok;
    bit    pe;
    bit    lk;
    string t;
    ok = exp_ok(op, blk, hv);
    t  = tag_of(op, blk);
    pe = (op <= 3'd1);
    lk = (op >= 3'd2) && (op <= 3'd4);
    req_vld = 1'b1; req_op = op; req_blk = IW'(blk); hv_ovr = hv;
    @(negedge clk);
    req_vld = 1'b0;
    if (ok) begin
      if (op == 3'd2) m_lock[blk] = 1'b1;
      if (op == 3'd3) m_mstr = 1'b1;
      if (op == 3'd4) m_lock = '0;
    end
    chk("R2 rsp_vld", 128'(rsp_vld), 128'(1));
    chk({t, " grant"}, 128'(rsp_grant), 128'(ok));
    chk({t, " fail"}, 128'(rsp_fail), 128'(!ok));
    chk(ok ? {t, " err_prog"} : "R8 err_prog", 128'(err_prog), 128'(!ok && pe));
    chk(ok ? {t, " err_lock"} : "R8 err_lock", 128'(err_lock), 128'(!ok && lk));
    chk(ok ? {t, " lock_vec"} : "R9 lock_vec", 128'(lock_vec), 128'(m_lock));
    chk(ok ? {t, " mstr_lock"} : "R9 mstr_lock", 128'(mstr_lock), 128'(m_mstr));
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk("R2 idle rsp_vld", 128'(rsp_vld), 128'(0));
    chk("R2 idle flags", 128'({rsp_grant, rsp_fail, err_lock, err_prog}), 128'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0] op;
    int         blk;
    logic       hv;
    void'($urandom(32'd20240611));
    m_lock = '0; m_mstr = 1'b0;
    rst_n = 1'b0; req_vld = 1'b0; req_op = 3'd0; req_blk = '0; hv_ovr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset lock_vec", 128'(lock_vec), 128'(0));
    chk("R1 reset mstr_lock", 128'(mstr_lock), 128'(0));
    chk("R1 reset rsp_vld", 128'(rsp_vld), 128'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 post-reset lock_vec", 128'(lock_vec), 128'(0));
    chk("R1 post-reset mstr", 128'(mstr_lock), 128'(0));

    // Directed: master clear
    issue(3'd0, 5, 1'b0);          // R3 unlocked program
    issue(3'd2, 5, 1'b0);          // R5 lock without override
    issue(3'd0, 5, 1'b0);          // R4 refused
    issue(3'd1, 5, 1'b1);          // R4 granted with override
    issue(3'd2, NB-1, 1'b0);       // R5 top sector
    issue(3'd2, 0, 1'b0);
    issue(3'd4, 0, 1'b0);          // R7 clear all at normal level
    idle_check();
    issue(3'd2, 10, 1'b0);
    issue(3'd6, 10, 1'b1);         // R10 reserved
    issue(3'd5, 3, 1'b0);          // R10 reserved
    issue(3'd7, 3, 1'b1);          // R10 reserved

    // Random, master held clear
    for (int i = 0; i < 300; i++) begin
      op  = 3'($urandom_range(0, 6));
      if (op == 3'd3) op = 3'd2;
      if (op == 3'd4 && ($urandom_range(0, 3) != 0)) op = 3'd2;
      blk = $urandom_range(0, NB-1);
      hv  = ($urandom_range(0, 3) == 0);
      issue(op, blk, hv);
      if ($urandom_range(0, 7) == 0) idle_check();
    end

    // Directed: master set
    issue(3'd3, 0, 1'b0);          // R6 refused
    issue(3'd3, 0, 1'b1);          // R6 granted
    issue(3'd2, 20, 1'b0);         // R5 refused
    issue(3'd2, 20, 1'b1);         // R5 granted
    issue(3'd4, 0, 1'b0);          // R7 refused
    issue(3'd4, 0, 1'b1);          // R7 granted
    issue(3'd3, 0, 1'b0);          // R6 refused, master stays
    idle_check();

    // Random, master set
    for (int i = 0; i < 400; i++) begin
      op  = 3'($urandom_range(0, 7));
      blk = $urandom_range(0, NB-1);
      hv  = ($urandom_range(0, 2) == 0);
      issue(op, blk, hv);
      if ($urandom_range(0, 7) == 0) idle_check();
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule